// File: doc/BRIEF.md
# Per-Direction Minimum-Gated Clock Offset Estimator

This block turns two-way time-transfer timestamps into an estimate of a slave clock's offset from its master and of the mean one-way path delay. Two independent sample streams feed it. On the forward stream each sample carries the master's send time and the slave's receive time. On the reverse stream each sample carries the slave's send time and the master's receive time. The block reduces each stream on its own. It does not wait for a single exchange that was fast in both directions. Instead it keeps the lowest transit difference seen in each direction over a window, and those two lows may come from unrelated exchanges. This only works when the slave's frequency is locked to the master's, so a lock input gates the whole block.

A window closes once each direction has taken its own programmed number of samples. The forward and reverse streams usually run at very different rates, so the two counts are separate. When the window closes, the block publishes offset and delay together with a one-cycle valid strobe. If one direction is switched off, it reports a one-cycle error strobe instead. A second mode replaces each direction's minimum with the mean of its differences. This mode suits Gaussian-like delay noise, where few packets see the floor delay. It uses a shared-shape sequential divider for each direction.

Top module: `min_gated_offset_est`

## Requirements
- R1: After reset, est_valid and est_error are 0 and est_offset and est_delay are 0.
- R2: Each forward sample gives Df = slave_rx − master_tx, and each reverse sample gives Dr = master_rx − slave_tx, both as 64-bit signed values. A result gives est_offset = floor((Df' − Dr')/2) and est_delay = floor((Df' + Dr')/2), where each halving is an arithmetic shift of the 65-bit exact sum or difference.
- R3: In minimum mode (avg_mode = 0), Df' and Dr' are the smallest Df and the smallest Dr of the window. Each is chosen independently, so the two may come from different exchanges.
- R4: A window closes only when the forward count has reached fwd_target and the reverse count has reached rev_target. Once a direction has reached its target, further samples in that direction are ignored until the window closes.
- R5: The two directions count their samples separately. A window with several forward samples and a single reverse sample produces no strobe until the last forward sample has been taken.
- R6: In averaging mode (avg_mode = 1), Df' and Dr' are the sum of each direction's differences divided by its sample count, truncated toward zero.
- R7: While freq_lock is 0, samples are ignored, any partial window is discarded, and neither est_valid nor est_error is raised. A window starts afresh when lock returns.
- R8: est_valid is a single-cycle pulse, and est_offset and est_delay hold their value until the next result.
- R9: A target of 0 disables that direction. If exactly one direction is disabled, its window closes with a one-cycle est_error pulse, no est_valid, and unchanged estimates. If both are disabled, no window closes.
- R10: Samples may give negative differences, and the first sample of a direction always becomes its minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_lock | input | 1 | Slave frequency locked; 0 suspends and clears the window |
| avg_mode | input | 1 | 0 = per-direction minimum, 1 = per-direction mean |
| fwd_target | input | 16 | Forward samples per window (0 disables) |
| rev_target | input | 16 | Reverse samples per window (0 disables) |
| fwd_valid | input | 1 | Forward sample present this cycle |
| fwd_master_tx | input | 64 | Master send time of forward sample (ns, signed) |
| fwd_slave_rx | input | 64 | Slave receive time of forward sample (ns, signed) |
| rev_valid | input | 1 | Reverse sample present this cycle |
| rev_slave_tx | input | 64 | Slave send time of reverse sample (ns, signed) |
| rev_master_rx | input | 64 | Master receive time of reverse sample (ns, signed) |
| est_valid | output | 1 | One-cycle strobe: new estimates available |
| est_error | output | 1 | One-cycle strobe: window closed with an empty direction |
| est_offset | output | 64 | Offset estimate (ns, signed) |
| est_delay | output | 64 | Mean path delay estimate (ns, signed) |

## Verification
The hardest cases to reach are those where the state the block has quietly carried decides the answer. One is a partial window abandoned by a lock drop. Another is a sample that arrives after its direction is already full. In each case the bench makes the discarded sample the smallest value in its direction. If it leaked into the result, the published offset would move by a known, easily distinguished amount. The bench also runs a forward stream ten times longer than the reverse one and watches the strobe counters to show that no result appears early. For averaging it picks odd sums with a negative reverse mean, so that truncation toward zero and the floor in the final halving give different answers than a naive rounding would.

// File: rtl/tsoff_pkg.sv
package tsoff_pkg;
  typedef enum logic [0:0] {
    PH_COLLECT = 1'b0,
    PH_DIVIDE  = 1'b1
  } phase_t;
endpackage

// File: rtl/tsoff_dir_acc.sv
module tsoff_dir_acc #(
  parameter int TS_W  = 64,
  parameter int CNT_W = 16,
  localparam int SUM_W = TS_W + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    take_i,
  input  logic signed [TS_W-1:0]  diff_i,
  input  logic [CNT_W-1:0]        target_i,
  output logic                    full_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic signed [TS_W-1:0]  min_o,
  output logic signed [SUM_W-1:0] sum_o
);
  localparam logic signed [TS_W-1:0] MAX_POS = {1'b0, {(TS_W-1){1'b1}}};

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [TS_W-1:0]  min_q, min_d;
  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic                    accept;

  assign full_o = (cnt_q >= target_i);
  assign accept = take_i && !full_o;

  always_comb begin
    cnt_d = cnt_q;
    min_d = min_q;
    sum_d = sum_q;
    if (clear_i) begin
      cnt_d = '0;
      min_d = MAX_POS;
      sum_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
      min_d = (diff_i < min_q) ? diff_i : min_q;
      sum_d = sum_q + {{CNT_W{diff_i[TS_W-1]}}, diff_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      min_q <= MAX_POS;
      sum_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      min_q <= min_d;
      sum_q <= sum_d;
    end
  end

  assign cnt_o = cnt_q;
  assign min_o = min_q;
  assign sum_o = sum_q;

  // R3
  min_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (min_q <= $past(min_q)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clear_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tsoff_sdiv.sv
module tsoff_sdiv #(
  parameter int NUM_W = 80,
  parameter int DEN_W = 16,
  parameter int OUT_W = 64,
  localparam int STEP_W = $clog2(NUM_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic signed [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0]        den_i,
  output logic                    busy_o,
  output logic signed [OUT_W-1:0] quot_o
);
  logic [NUM_W-1:0]  mag_q, mag_d;
  logic [DEN_W-1:0]  rem_q, rem_d;
  logic              neg_q, neg_d;
  logic              busy_q, busy_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [DEN_W:0]    rem_sh, rem_sub;
  logic              ge;
  logic [NUM_W-1:0]  signed_mag;

  assign rem_sh  = {rem_q, mag_q[NUM_W-1]};
  assign rem_sub = rem_sh - {1'b0, den_i};
  assign ge      = (rem_sh >= {1'b0, den_i});

  always_comb begin
    mag_d   = mag_q;
    rem_d   = rem_q;
    neg_d   = neg_q;
    busy_d  = busy_q;
    steps_d = steps_q;
    if (start_i) begin
      neg_d   = num_i[NUM_W-1];
      mag_d   = num_i[NUM_W-1] ? (~num_i + 1'b1) : num_i;
      rem_d   = '0;
      steps_d = STEP_W'(NUM_W);
      busy_d  = 1'b1;
    end else if (busy_q) begin
      rem_d   = ge ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
      mag_d   = {mag_q[NUM_W-2:0], ge};
      steps_d = steps_q - 1'b1;
      busy_d  = (steps_q != STEP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q   <= '0;
      rem_q   <= '0;
      neg_q   <= 1'b0;
      busy_q  <= 1'b0;
      steps_q <= '0;
    end else begin
      mag_q   <= mag_d;
      rem_q   <= rem_d;
      neg_q   <= neg_d;
      busy_q  <= busy_d;
      steps_q <= steps_d;
    end
  end

  assign signed_mag = neg_q ? (~mag_q + 1'b1) : mag_q;
  assign quot_o     = OUT_W'(signed_mag);
  assign busy_o     = busy_q;

  // R6
  div_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  // R6
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (den_i != '0));
endmodule

// File: rtl/min_gated_offset_est.sv
module min_gated_offset_est
  import tsoff_pkg::*;
#(
  parameter int TS_W  = 64,
  parameter int CNT_W = 16,
  localparam int SUM_W = TS_W + CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   freq_lock,
  input  logic                   avg_mode,
  input  logic [CNT_W-1:0]       fwd_target,
  input  logic [CNT_W-1:0]       rev_target,
  input  logic                   fwd_valid,
  input  logic [TS_W-1:0]        fwd_master_tx,
  input  logic [TS_W-1:0]        fwd_slave_rx,
  input  logic                   rev_valid,
  input  logic [TS_W-1:0]        rev_slave_tx,
  input  logic [TS_W-1:0]        rev_master_rx,
  output logic                   est_valid,
  output logic                   est_error,
  output logic [TS_W-1:0]        est_offset,
  output logic [TS_W-1:0]        est_delay
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  phase_t phase_q, phase_d;
  logic   collecting, acc_clear, win_end, win_bad, div_start, div_done, any_en;
  logic   f_take, r_take, f_full, r_full, f_busy, r_busy;
  logic [CNT_W-1:0]        f_cnt, r_cnt;
  logic signed [TS_W-1:0]  fwd_diff, rev_diff, f_min, r_min, f_quot, r_quot, f_val, r_val;
  logic signed [SUM_W-1:0] f_sum, r_sum;
  logic signed [TS_W:0]    off_full, dly_full;
  logic                    valid_d, error_d, valid_q, error_q;
  logic [TS_W-1:0]         offset_d, delay_d, offset_q, delay_q;

  assign fwd_diff = fwd_slave_rx - fwd_master_tx;
  assign rev_diff = rev_master_rx - rev_slave_tx;

  assign collecting = (phase_q == PH_COLLECT);
  assign f_take     = fwd_valid && freq_lock && collecting;
  assign r_take     = rev_valid && freq_lock && collecting;
  assign any_en     = (fwd_target != '0) || (rev_target != '0);
  assign win_end    = collecting && freq_lock && any_en && f_full && r_full;
  assign win_bad    = (f_cnt == '0) || (r_cnt == '0);
  assign div_start  = win_end && !win_bad && avg_mode;
  assign div_done   = (phase_q == PH_DIVIDE) && freq_lock && !f_busy && !r_busy;
  assign acc_clear  = !freq_lock || (win_end && !div_start) || div_done;

  tsoff_dir_acc #(.TS_W(TS_W), .CNT_W(CNT_W)) u_fwd_acc (
    .clk(clk), .rst_n(core_rst_n), .clear_i(acc_clear), .take_i(f_take),
    .diff_i(fwd_diff), .target_i(fwd_target), .full_o(f_full),
    .cnt_o(f_cnt), .min_o(f_min), .sum_o(f_sum));

  tsoff_dir_acc #(.TS_W(TS_W), .CNT_W(CNT_W)) u_rev_acc (
    .clk(clk), .rst_n(core_rst_n), .clear_i(acc_clear), .take_i(r_take),
    .diff_i(rev_diff), .target_i(rev_target), .full_o(r_full),
    .cnt_o(r_cnt), .min_o(r_min), .sum_o(r_sum));

  tsoff_sdiv #(.NUM_W(SUM_W), .DEN_W(CNT_W), .OUT_W(TS_W)) u_fwd_div (
    .clk(clk), .rst_n(core_rst_n), .start_i(div_start), .num_i(f_sum),
    .den_i(f_cnt), .busy_o(f_busy), .quot_o(f_quot));

  tsoff_sdiv #(.NUM_W(SUM_W), .DEN_W(CNT_W), .OUT_W(TS_W)) u_rev_div (
    .clk(clk), .rst_n(core_rst_n), .start_i(div_start), .num_i(r_sum),
    .den_i(r_cnt), .busy_o(r_busy), .quot_o(r_quot));

  assign f_val    = (phase_q == PH_DIVIDE) ? f_quot : f_min;
  assign r_val    = (phase_q == PH_DIVIDE) ? r_quot : r_min;
  assign off_full = {f_val[TS_W-1], f_val} - {r_val[TS_W-1], r_val};
  assign dly_full = {f_val[TS_W-1], f_val} + {r_val[TS_W-1], r_val};

  always_comb begin
    phase_d = phase_q;
    if (!freq_lock)     phase_d = PH_COLLECT;
    else if (div_start) phase_d = PH_DIVIDE;
    else if (div_done)  phase_d = PH_COLLECT;
  end

  always_comb begin
    valid_d  = (win_end && !win_bad && !avg_mode) || div_done;
    error_d  = win_end && win_bad;
    offset_d = offset_q;
    delay_d  = delay_q;
    if (valid_d) begin
      offset_d = TS_W'(off_full >>> 1);
      delay_d  = TS_W'(dly_full >>> 1);
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      phase_q  <= PH_COLLECT;
      valid_q  <= 1'b0;
      error_q  <= 1'b0;
      offset_q <= '0;
      delay_q  <= '0;
    end else begin
      phase_q  <= phase_d;
      valid_q  <= valid_d;
      error_q  <= error_d;
      offset_q <= offset_d;
      delay_q  <= delay_d;
    end
  end

  assign est_valid  = valid_q;
  assign est_error  = error_q;
  assign est_offset = offset_q;
  assign est_delay  = delay_q;

  // R7
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !freq_lock |=> (!est_valid && !est_error));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    est_valid |=> !est_valid);

  // R8
  hold_est_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !valid_d |=> ($stable(est_offset) && $stable(est_delay)));

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({est_valid, est_error}));
endmodule

// File: tb/tb_min_gated_offset_est.sv
module tb_min_gated_offset_est;
  logic        clk = 1'b0;
  logic        rst_n, freq_lock, avg_mode, fwd_valid, rev_valid;
  logic [15:0] fwd_target, rev_target;
  logic [63:0] fwd_master_tx, fwd_slave_rx, rev_slave_tx, rev_master_rx;
  logic        est_valid, est_error;
  logic [63:0] est_offset, est_delay;

  int n_checks = 0, n_fail = 0, n_valid = 0, n_err = 0;
  longint ts_base = 64'sd5000000000000;

  always #4 clk = ~clk;

  min_gated_offset_est dut (
    .clk(clk), .rst_n(rst_n), .freq_lock(freq_lock), .avg_mode(avg_mode),
    .fwd_target(fwd_target), .rev_target(rev_target),
    .fwd_valid(fwd_valid), .fwd_master_tx(fwd_master_tx), .fwd_slave_rx(fwd_slave_rx),
    .rev_valid(rev_valid), .rev_slave_tx(rev_slave_tx), .rev_master_rx(rev_master_rx),
    .est_valid(est_valid), .est_error(est_error),
    .est_offset(est_offset), .est_delay(est_delay));

  always @(negedge clk) begin
    if (est_valid) n_valid++;
    if (est_error) n_err++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic [63:0] half_diff(input longint a, input longint b);
    logic signed [64:0] t;
    t = {a[63], a} - {b[63], b};
    return t[64:1];
  endfunction

  function automatic logic [63:0] half_sum(input longint a, input longint b);
    logic signed [64:0] t;
    t = {a[63], a} + {b[63], b};
    return t[64:1];
  endfunction

  task automatic send_fwd(input longint d);
    @(negedge clk);
    ts_base += 1000;
    fwd_master_tx = ts_base;
    fwd_slave_rx  = ts_base + d;
    fwd_valid = 1'b1;
    @(negedge clk);
    fwd_valid = 1'b0;
  endtask

  task automatic send_rev(input longint d);
    @(negedge clk);
    ts_base += 1000;
    rev_slave_tx  = ts_base;
    rev_master_rx = ts_base + d;
    rev_valid = 1'b1;
    @(negedge clk);
    rev_valid = 1'b0;
  endtask

  task automatic restart(input logic mode, input logic [15:0] ft, input logic [15:0] rt);
    @(negedge clk);
    freq_lock = 1'b0;
    avg_mode = mode; fwd_target = ft; rev_target = rt;
    repeat (2) @(negedge clk);
    freq_lock = 1'b1;
  endtask

  task automatic wait_result(input string req, input int limit);
    bit seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (est_valid || est_error) seen = 1;
    end
    chk({req, " result strobe seen"}, 64'(seen), 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(est_valid), 64'd0);
    chk("R1 error", 64'(est_error), 64'd0);
    chk("R1 offset", est_offset, 64'd0);
    chk("R1 delay", est_delay, 64'd0);
  endtask

  // R3: forward min from exchange 2, reverse min from exchange 2 of a different pair
  task automatic t_min_basic;
    restart(1'b0, 16'd3, 16'd2);
    send_fwd(750); send_rev(150); send_fwd(550); send_rev(50); send_fwd(950);
    wait_result("R3", 10);
    chk("R3 valid", 64'(est_valid), 64'd1);
    chk("R3 offset", est_offset, half_diff(550, 50));
    chk("R2 delay", est_delay, half_sum(550, 50));
    @(negedge clk);
    chk("R8 pulse width", 64'(est_valid), 64'd0);
    repeat (5) @(negedge clk);
    chk("R8 offset held", est_offset, half_diff(550, 50));
  endtask

  // R10 / R2: negative offset, odd difference, floor halving
  task automatic t_negative;
    restart(1'b0, 16'd1, 16'd1);
    send_fwd(199); send_rev(402);
    wait_result("R10", 10);
    chk("R10 offset floor", est_offset, 64'hFFFF_FFFF_FFFF_FF9A);
    chk("R2 delay", est_delay, 64'd300);
  endtask

  // R5, R4: unequal counts, extra reverse sample ignored
  task automatic t_rates;
    int v0;
    restart(1'b0, 16'd10, 16'd1);
    v0 = n_valid;
    send_rev(80); send_rev(20);
    for (int k = 0; k < 9; k++) send_fwd(300 - k * 10);
    repeat (4) @(negedge clk);
    chk("R5 no early result", 64'(n_valid - v0), 64'd0);
    send_fwd(400);
    wait_result("R5", 10);
    chk("R4 extra sample ignored offset", est_offset, half_diff(220, 80));
    chk("R4 delay", est_delay, half_sum(220, 80));
  endtask

  // R6: averaging, truncation toward zero on a negative mean
  task automatic t_average;
    restart(1'b1, 16'd4, 16'd2);
    send_fwd(100); send_rev(-10); send_fwd(200); send_fwd(300); send_rev(-25); send_fwd(401);
    wait_result("R6", 300);
    chk("R6 valid", 64'(est_valid), 64'd1);
    chk("R6 offset", est_offset, half_diff(250, -17));
    chk("R6 delay", est_delay, half_sum(250, -17));
    @(negedge clk);
    chk("R8 avg pulse width", 64'(est_valid), 64'd0);
  endtask

  // R7: lock drop discards partial window and blocks samples
  task automatic t_lock;
    int v0, e0;
    restart(1'b0, 16'd2, 16'd1);
    send_fwd(10);
    @(negedge clk); freq_lock = 1'b0;
    v0 = n_valid; e0 = n_err;
    send_fwd(5); send_rev(1); send_fwd(6);
    repeat (10) @(negedge clk);
    chk("R7 no valid while unlocked", 64'(n_valid - v0), 64'd0);
    chk("R7 no error while unlocked", 64'(n_err - e0), 64'd0);
    freq_lock = 1'b1;
    send_fwd(500); send_fwd(600); send_rev(100);
    wait_result("R7", 10);
    chk("R7 stale min discarded", est_offset, half_diff(500, 100));
  endtask

  // R9: disabled directions
  task automatic t_disabled;
    int v0, e0;
    logic [63:0] held;
    held = est_offset;
    restart(1'b0, 16'd0, 16'd2);
    v0 = n_valid; e0 = n_err;
    send_rev(40); send_rev(30);
    wait_result("R9", 10);
    chk("R9 error raised", 64'(est_error), 64'd1);
    chk("R9 no valid", 64'(n_valid - v0), 64'd0);
    chk("R9 offset unchanged", est_offset, held);
    @(negedge clk);
    chk("R9 error one cycle", 64'(est_error), 64'd0);
    restart(1'b0, 16'd0, 16'd0);
    v0 = n_valid; e0 = n_err;
    send_fwd(1); send_rev(2);
    repeat (20) @(negedge clk);
    chk("R9 both disabled quiet", 64'((n_valid - v0) + (n_err - e0)), 64'd0);
  endtask

  bit finished = 0;

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; freq_lock = 1'b0; avg_mode = 1'b0;
    fwd_target = '0; rev_target = '0; fwd_valid = 1'b0; rev_valid = 1'b0;
    fwd_master_tx = '0; fwd_slave_rx = '0; rev_slave_tx = '0; rev_master_rx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_min_basic();
    t_negative();
    t_rates();
    t_average();
    t_lock();
    t_disabled();
    summary();
  end
endmodule